// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller with Flow-Through Reads

This block is a synchronous static RAM with an on-chip burst engine, sized by parameters to a small array. Every synchronous input is sampled on the rising clock edge. A bus master starts an access with one of two address strobes. The CPU-side strobe is gated by the first chip select and always opens a read. The controller-side strobe opens a read or a write, depending on the write-enable pins in that cycle. After the start, the block produces the remaining beats of a 4-beat burst by itself. A pin picks either a linear or an XOR-interleaved order, and an advance pin either moves the burst on or holds it for a wait state.

A read is flow-through. The word at the address registered on an edge appears on `dout` in the cycle that follows that edge, with no extra pipeline stage. A write takes its data on the same edge as its address. Each 36-bit word is made of four 9-bit byte lanes (8 data bits and 1 parity bit), and every lane can be written on its own. `dq_oe` is the drive enable for an external pad driver: while it is low, the data bus must be treated as high-impedance. A sleep input freezes the block and keeps the array contents. After a wake-up, the first two edges refuse any new start and report each refused attempt on `wake_err`.

There is no streaming payload at the edge of this block. The interface is the SRAM pin protocol, so there is no valid/ready handshake and no back-pressure. The bus master owns the timing.

Top module: `sbsram_ctrl`

## Requirements
- R1: The device counts as selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A start attempt with any other combination deselects it: `dq_oe` goes low after that edge, and the following strobe-free cycles neither read nor write.
- R2: While `sel_a_n`=1, a low `astb_cpu_n` is ignored, and an active burst carries on as if no strobe were present. A low `astb_ctl_n` still deselects the device.
- R3: A selected start through `astb_cpu_n` is always a read at `addr`, whatever the write inputs are. A start through `astb_ctl_n` (with `astb_cpu_n` high) is a write when the decoded lane mask is non-zero, and a read otherwise.
- R4: A start loads the low two address bits as the burst start s, and beat k (0 to 3) addresses low bits (s+k) mod 4 when `order_ilv`=0, or s XOR k when `order_ilv`=1. The upper bits stay fixed. After beat 3 the sequence wraps back to s.
- R5: On a strobe-free edge of an active burst, `adv_n`=0 moves to the next beat and `adv_n`=1 repeats the current address as a wait state. `adv_n` is ignored on a start edge, which always accesses beat 0.
- R6: `gwe_n`=0 writes all four lanes. With `gwe_n`=1 and `bwe_n`=0, lane i is written exactly when `lane_we_n[i]`=0. Lane i is `din[9i+8:9i]`. When no lane is enabled, the cycle is a read. Strobe-free burst cycles are also read or write according to this decode.
- R7: After an edge that performs a read, `dout` shows the stored word at that address in the same cycle, and `dq_oe` is high while `oe_n` is low.
- R8: `dq_oe` follows `oe_n` without a clock (`oe_n`=1 forces it low), and it is low after write, deselect and no-access edges.
- R9: While `sleep`=1, `dq_oe` is low at once, no edge reads or writes, and the array and burst state are kept.
- R10: The first two edges after `sleep` returns low ignore any start. A strobe on either of those edges raises `wake_err` for the one cycle that follows it. The third edge accepts starts normally.
- R11: After reset, no burst is active, `dq_oe` and `wake_err` are low, and there is no wake-up window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| astb_cpu_n | input | 1 | CPU-side address strobe, active low |
| astb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select A, active low; also gates the CPU-side strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| gwe_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Flow-through read data |
| dq_oe | output | 1 | Data drive enable; low means the bus is high-impedance |
| wake_err | output | 1 | One-cycle pulse for a start refused during the wake-up window |

## Verification
A wrong burst counter or base register shows at the ports as `dout` carrying the word of a neighbouring address. Because reads are flow-through, this is visible in the cycle right after the faulty edge. A wrong lane decode stays invisible until that address is read back, so each byte-write sweep step is followed at once by a single read of the same word. A stale wake-up counter or read-phase flag shows as `dq_oe` or `wake_err` being wrong one edge after the sleep release or after the deselect.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  // Low address bits of burst beat k from start s.
  function automatic logic [1:0] beat_addr(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/sbsram_wdec.sv
module sbsram_wdec #(
  parameter int LANES = 4
) (
  input  logic             gwe_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_we_n,
  output logic [LANES-1:0] wr_lanes
);
  always_comb begin
    if (!gwe_n)      wr_lanes = '1;
    else if (!bwe_n) wr_lanes = ~lane_we_n;
    else             wr_lanes = '0;
  end
endmodule

// File: rtl/sbsram_seq.sv
module sbsram_seq #(
  parameter int ADDR_W   = 6,
  parameter int LANES    = 4,
  parameter int WAKE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              astb_cpu_n,
  input  logic              astb_ctl_n,
  input  logic              adv_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              order_ilv,
  input  logic              sleep,
  input  logic [LANES-1:0]  wr_lanes,
  output logic [LANES-1:0]  acc_we,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              rd_phase,
  output logic              wake_err
);
  localparam int WCW = $clog2(WAKE_CYC + 1);

  logic              active_q, rd_q, err_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q, beat_nxt;
  logic [WCW-1:0]    wake_q;
  logic blocked, cpu_go, any_go, selected, start_ok, desel, cont, rd_access;

  always_comb begin
    blocked   = sleep || (wake_q != '0);
    cpu_go    = !astb_cpu_n && !sel_a_n;
    any_go    = cpu_go || !astb_ctl_n;
    selected  = !sel_a_n && sel_b && !sel_c_n;
    start_ok  = !blocked && any_go && selected;
    desel     = !blocked && any_go && !selected;
    cont      = !blocked && !any_go && active_q;
    beat_nxt  = adv_n ? beat_q : beat_q + 2'd1;
    if (start_ok)
      acc_addr = addr;
    else
      acc_addr = {base_q[ADDR_W-1:2],
                  sbsram_pkg::beat_addr(base_q[1:0], beat_nxt, order_ilv)};
    if ((start_ok && !cpu_go) || cont) acc_we = wr_lanes;
    else                               acc_we = '0;
    rd_access = (start_ok || cont) && (acc_we == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      err_q    <= 1'b0;
      base_q   <= '0;
      beat_q   <= 2'd0;
      wake_q   <= '0;
    end else begin
      if (start_ok) begin
        active_q <= 1'b1;
        base_q   <= addr;
        beat_q   <= 2'd0;
      end else if (desel) begin
        active_q <= 1'b0;
      end else if (cont) begin
        beat_q   <= beat_nxt;
      end
      rd_q  <= rd_access;
      err_q <= !sleep && (wake_q != '0) && (!astb_cpu_n || !astb_ctl_n);
      if (sleep)              wake_q <= WCW'(WAKE_CYC);
      else if (wake_q != '0)  wake_q <= wake_q - 1'b1;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:2],
                     sbsram_pkg::beat_addr(base_q[1:0], beat_q, order_ilv)};
  assign rd_phase = rd_q;
  assign wake_err = err_q;
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl #(
  parameter int ADDR_W   = 6,
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    astb_cpu_n,
  input  logic                    astb_ctl_n,
  input  logic                    adv_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    gwe_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    order_ilv,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dq_oe,
  output logic                    wake_err
);
  logic [LANES-1:0]  wr_lanes, acc_we;
  logic [ADDR_W-1:0] acc_addr, cur_addr;
  logic              rd_phase;

  sbsram_wdec #(.LANES(LANES)) u_wdec (
    .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n), .wr_lanes(wr_lanes)
  );

  sbsram_seq #(.ADDR_W(ADDR_W), .LANES(LANES), .WAKE_CYC(WAKE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .astb_cpu_n(astb_cpu_n), .astb_ctl_n(astb_ctl_n), .adv_n(adv_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .order_ilv(order_ilv), .sleep(sleep), .wr_lanes(wr_lanes),
    .acc_we(acc_we), .acc_addr(acc_addr), .cur_addr(cur_addr),
    .rd_phase(rd_phase), .wake_err(wake_err)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(acc_we), .waddr(acc_addr), .wdata(din),
    .raddr(cur_addr), .rdata(dout)
  );

  // Output drive is released asynchronously by oe_n and sleep.
  assign dq_oe = rd_phase && !oe_n && !sleep;
endmodule

// File: rtl/sbsram_ctrl_chk.sv
module sbsram_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic astb_cpu_n,
  input logic astb_ctl_n,
  input logic sel_a_n,
  input logic sel_b,
  input logic sel_c_n,
  input logic gwe_n,
  input logic oe_n,
  input logic sleep,
  input logic dq_oe,
  input logic wake_err
);
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!astb_ctl_n && !(!sel_a_n && sel_b && !sel_c_n)) |=> !dq_oe); // R1

  AST_CTL_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!astb_ctl_n && astb_cpu_n && !gwe_n) |=> !dq_oe); // R6

  AST_OEN_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe); // R8

  AST_SLEEP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe); // R9

  AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && $past(sleep)) |=> !dq_oe); // R10

  AST_WAKE_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_err |-> $past(!astb_cpu_n || !astb_ctl_n)); // R10
endmodule

bind sbsram_ctrl sbsram_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .astb_cpu_n(astb_cpu_n), .astb_ctl_n(astb_ctl_n),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .gwe_n(gwe_n),
  .oe_n(oe_n), .sleep(sleep), .dq_oe(dq_oe), .wake_err(wake_err)
);

// File: tb/sbsram_ctrl_test.sv
module sbsram_ctrl_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic astb_cpu_n = 1, astb_ctl_n = 1, adv_n = 1;
  logic sel_a_n = 0, sel_b = 1, sel_c_n = 0;
  logic gwe_n = 1, bwe_n = 1;
  logic [3:0] lane_we_n = 4'hF;
  logic order_ilv = 0, oe_n = 0, sleep = 0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic dq_oe, wake_err;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [35:0] mdl [DEPTH];

  always #2 clk = ~clk;

  sbsram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .astb_cpu_n(astb_cpu_n),
    .astb_ctl_n(astb_ctl_n), .adv_n(adv_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n),
    .order_ilv(order_ilv), .oe_n(oe_n), .sleep(sleep), .din(din),
    .dout(dout), .dq_oe(dq_oe), .wake_err(wake_err)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    astb_cpu_n = 1; astb_ctl_n = 1; adv_n = 1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    gwe_n = 1; bwe_n = 1; lane_we_n = 4'hF; oe_n = 0; sleep = 0;
  endtask

  function automatic logic [35:0] pat(input int a);
    return 36'h9A5C31E70 ^ (36'(a) * 36'h001010203);
  endfunction

  function automatic logic [1:0] lowk(input int s, input int k, input bit ilv);
    return ilv ? 2'(s ^ k) : 2'((s + k) % 4);
  endfunction

  task automatic wr_full(input int a, input logic [35:0] d);
    astb_ctl_n = 0; addr = AW'(a); din = d; gwe_n = 0;
    step();
    mdl[a] = d;
    idle();
  endtask

  task automatic rd_one(input int a, input string req);
    astb_ctl_n = 0; addr = AW'(a);
    step();
    chk({req, " read dq_oe"}, 36'(dq_oe), 36'd1);
    chk({req, " read data"}, dout, mdl[a]);
    idle();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) step();
    rst_n = 1;
    #1;
    chk("R11 reset dq_oe", 36'(dq_oe), 36'd0);
    chk("R11 reset wake_err", 36'(wake_err), 36'd0);
    step();
    chk("R11 idle after reset no access", 36'(dq_oe), 36'd0);

    // Fill every word with full writes, then check them back (R3, R6, R7).
    for (int a = 0; a < DEPTH; a++) begin
      wr_full(a, pat(a));
      chk("R8 dq_oe low after write", 36'(dq_oe), 36'd0);
    end
    for (int a = 0; a < DEPTH; a++) rd_one(a, "R7");

    // Asynchronous output enable during a read phase (R8).
    rd_one(11, "R7");
    oe_n = 1; #1;
    chk("R8 oe_n high releases", 36'(dq_oe), 36'd0);
    oe_n = 0; #1;
    chk("R8 oe_n low drives", 36'(dq_oe), 36'd1);

    // Burst order sweep over both modes and all starts, with one wait state (R3, R4, R5).
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        int hi;
        hi = 4 + 2 * s + m;
        order_ilv = m[0];
        astb_cpu_n = 0; addr = AW'(hi * 4 + s); gwe_n = 0; adv_n = 0;
        step();
        chk("R3 cpu start is read", 36'(dq_oe), 36'd1);
        chk("R5 start beat0 adv ignored", dout, mdl[hi * 4 + s]);
        astb_cpu_n = 1; gwe_n = 1;
        for (int k = 1; k <= 4; k++) begin
          if (k == 2) begin
            adv_n = 1;
            step();
            chk("R5 wait state holds", dout, mdl[hi * 4 + int'(lowk(s, 1, m[0]))]);
            adv_n = 0;
          end
          step();
          chk("R4 burst beat", dout, mdl[hi * 4 + int'(lowk(s, k % 4, m[0]))]);
        end
        idle();
      end
    end
    order_ilv = 0;

    // Controller-started write burst with continue and suspend writes (R6).
    astb_ctl_n = 0; addr = AW'(32 + 2); gwe_n = 0; din = 36'h111111111;
    step();
    mdl[34] = 36'h111111111;
    astb_ctl_n = 1; adv_n = 0;
    for (int k = 1; k < 4; k++) begin
      din = 36'h222222222 * 36'(k);
      step();
      mdl[32 + (2 + k) % 4] = 36'h222222222 * 36'(k);
    end
    adv_n = 1; din = 36'hABCDEF012;
    step();
    mdl[33] = 36'hABCDEF012;
    idle();
    for (int a = 32; a < 36; a++) rd_one(a, "R6 burst write");

    // Byte-lane sweep (R6).
    for (int msk = 0; msk < 16; msk++) begin
      int a;
      logic [35:0] nd, ex;
      a = 48 + msk;
      nd = ~pat(a) ^ 36'(msk * 7);
      ex = mdl[a];
      for (int l = 0; l < 4; l++) if (!msk[l]) ex[l*9 +: 9] = nd[l*9 +: 9];
      astb_ctl_n = 0; addr = AW'(a); din = nd; bwe_n = 0; lane_we_n = 4'(msk);
      step();
      chk("R6 no-lane cycle is read", 36'(dq_oe), (msk == 15) ? 36'd1 : 36'd0);
      mdl[a] = ex;
      idle();
      rd_one(a, "R6 lane merge");
    end
    astb_ctl_n = 0; addr = AW'(47); din = 36'h0F0F0F0F0; bwe_n = 0; lane_we_n = 4'b1110; gwe_n = 0;
    step();
    mdl[47] = 36'h0F0F0F0F0;
    idle();
    rd_one(47, "R6 global overrides lanes");

    // Chip-select combinations (R1).
    for (int c = 0; c < 8; c++) begin
      astb_ctl_n = 0; addr = AW'(5);
      sel_a_n = c[0]; sel_b = c[1]; sel_c_n = c[2];
      step();
      chk("R1 select decode", 36'(dq_oe), (c == 2) ? 36'd1 : 36'd0);
      if (c != 2) begin
        astb_ctl_n = 1; adv_n = 0; gwe_n = 0; din = 36'hDEADBEEF0;
        sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        step();
        chk("R1 deselected no access", 36'(dq_oe), 36'd0);
      end
      idle();
    end
    for (int a = 4; a < 8; a++) rd_one(a, "R1 contents kept");

    // First chip select high blocks the CPU strobe only (R2).
    astb_cpu_n = 0; addr = AW'(20);
    step();
    astb_cpu_n = 0; sel_a_n = 1; adv_n = 0;
    step();
    chk("R2 blocked cpu strobe continues burst", dout, mdl[21]);
    chk("R2 blocked cpu strobe still reads", 36'(dq_oe), 36'd1);
    astb_cpu_n = 1; astb_ctl_n = 0; adv_n = 1;
    step();
    chk("R2 ctl strobe deselects", 36'(dq_oe), 36'd0);
    idle();

    // Sleep and wake-up window (R9, R10).
    rd_one(7, "R9");
    sleep = 1; #1;
    chk("R9 sleep releases bus", 36'(dq_oe), 36'd0);
    astb_ctl_n = 0; addr = AW'(7); gwe_n = 0; din = 36'h0BADBAD00;
    step();
    chk("R9 no error while asleep", 36'(wake_err), 36'd0);
    step();
    sleep = 0;
    step();
    chk("R10 wake edge1 error", 36'(wake_err), 36'd1);
    chk("R10 wake edge1 no drive", 36'(dq_oe), 36'd0);
    gwe_n = 1; addr = AW'(9);
    step();
    chk("R10 wake edge2 error", 36'(wake_err), 36'd1);
    chk("R10 wake edge2 no read", 36'(dq_oe), 36'd0);
    addr = AW'(7);
    step();
    chk("R10 third edge accepted", 36'(dq_oe), 36'd1);
    chk("R10 error cleared", 36'(wake_err), 36'd0);
    chk("R9 contents preserved", dout, mdl[7]);
    idle();
    step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule